// File: doc/BRIEF.md
# Soft-Symbol Erasure and Descramble Front End

This block sits in front of a rate-1/2 Viterbi decoder. On each accepted symbol it takes two 3-bit soft-decision channel values, called G1 and G2, and produces a registered pair of branch metrics for each of them. The soft values are offset-binary: 0 is a confident zero and 7 is a confident one. For a value v, the metric for the "bit was 0" hypothesis is v and the metric for the "bit was 1" hypothesis is 7 - v.

Two controls change that mapping. A descramble control complements the G2 value before its metrics are formed, which undoes a G2-inverting scrambler at the encoder. G1 is never inverted. Per-symbol erasure flags, sampled together with the symbols, replace a symbol's metrics with a neutral (0,0) pair. These flags act only when the 3-bit rate field is 000, the external-erasure code. Any other rate code turns the flags off and is passed downstream with the metrics, for use by an internal puncture controller.

A small mode machine records how the captured symbol must be treated. It has three states:
- `ST_IDLE`: no symbol is held.
- `ST_EXT`: a symbol is held and its erasure flags are honoured.
- `ST_INT`: a symbol is held and its erasure flags are ignored.

From any state, a strobe with rate 000 moves the machine to `ST_EXT`, and a strobe with any other rate moves it to `ST_INT`. A cycle with no strobe moves it to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `rsd_depunct_front`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `bm_valid` is 0 and all four metric outputs and `bm_rate` are 0.
- R2: For an unerased symbol of value v, with v taken after any inversion, the "0" metric equals v and the "1" metric equals 7 - v.
- R3: With `g2_descr` high at the strobe, the G2 metrics are formed from the bitwise complement of `g2_soft`. The G1 metrics are never affected by `g2_descr`.
- R4: With `rate_sel` = 000 and `g1_erase` high at the strobe, both G1 metrics are 0 whatever `g1_soft` holds. The G2 metrics are unaffected.
- R5: With `rate_sel` = 000 and `g2_erase` high at the strobe, both G2 metrics are 0 whatever `g2_soft` holds. The G1 metrics are unaffected.
- R6: With `rate_sel` other than 000, both erasure flags have no effect on the metrics.
- R7: A symbol sampled at clock edge k (with `sym_stb` high) appears on the outputs after edge k+1, and `bm_valid` is high for exactly that one cycle. With no strobe at edge k, `bm_valid` is low after edge k+1.
- R8: `bm_rate` shows the `rate_sel` value that was sampled with the symbol currently on the outputs.
- R9: When `bm_valid` is low, the metric outputs and `bm_rate` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; symbols are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | High for one symbol to be sampled at this edge |
| g1_soft | input | 3 | G1 soft value, offset-binary |
| g2_soft | input | 3 | G2 soft value, offset-binary |
| g2_descr | input | 1 | Complement G2 before forming metrics |
| g1_erase | input | 1 | Erase G1 (honoured only when rate is 000) |
| g2_erase | input | 1 | Erase G2 (honoured only when rate is 000) |
| rate_sel | input | 3 | Rate code; 000 selects external erasure |
| bm_valid | output | 1 | Metric pair valid |
| g1_bm0 | output | 3 | G1 metric for hypothesis 0 |
| g1_bm1 | output | 3 | G1 metric for hypothesis 1 |
| g2_bm0 | output | 3 | G2 metric for hypothesis 0 |
| g2_bm1 | output | 3 | G2 metric for hypothesis 1 |
| bm_rate | output | 3 | Rate code sampled with the current symbol |

## Verification
The properties assume that every input is a known 0/1 value at each rising edge. They also assume that reset is held for at least one edge before the two-cycle windows are judged; the `disable iff` on reset covers any window that reset interrupts.

The stimulus meets these assumptions in two ways. All inputs are driven on the falling edge, always to defined values. Reset is raised for two full cycles both at start-up and in the middle of the run. Strobes are mixed back-to-back and with gaps, so the latency, hold and erasure windows all open while reset is low.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXT  = 2'd1,
        ST_INT  = 2'd2
    } rsd_state_t;

endpackage

// File: rtl/rsd_mode_fsm.sv
module rsd_mode_fsm
    import rsd_pkg::*;
#(
    parameter int RATE_W = 3,
    parameter logic [RATE_W-1:0] EXT_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_stb,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              honor_flags,
    output logic              sym_held
);

    rsd_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: every state follows the current strobe
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_EXT, ST_INT: begin
                if (!sym_stb) begin
                    state_d = ST_IDLE;
                end else if (rate_sel == EXT_CODE) begin
                    state_d = ST_EXT;
                end else begin
                    state_d = ST_INT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        honor_flags = 1'b0;
        sym_held    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                honor_flags = 1'b0;
                sym_held    = 1'b0;
            end
            ST_EXT: begin
                honor_flags = 1'b1;
                sym_held    = 1'b1;
            end
            ST_INT: begin
                honor_flags = 1'b0;
                sym_held    = 1'b1;
            end
            default: begin
                honor_flags = 1'b0;
                sym_held    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsd_sym_capture.sv
module rsd_sym_capture #(
    parameter int SOFT_W = 3,
    parameter int RATE_W = 3,
    parameter int NCH    = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sym_stb,
    input  logic [NCH-1:0][SOFT_W-1:0]   sym_in,
    input  logic [NCH-1:0]               invert,
    input  logic [NCH-1:0]               erase_in,
    input  logic [RATE_W-1:0]            rate_in,
    output logic [NCH-1:0][SOFT_W-1:0]   sym_q,
    output logic [NCH-1:0]               erase_q,
    output logic [RATE_W-1:0]            rate_q
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        logic [SOFT_W-1:0] soft_r;
        logic              era_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                soft_r <= '0;
                era_r  <= 1'b0;
            end else if (sym_stb) begin
                soft_r <= invert[ch] ? ~sym_in[ch] : sym_in[ch];
                era_r  <= erase_in[ch];
            end
        end
        assign sym_q[ch]   = soft_r;
        assign erase_q[ch] = era_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else if (sym_stb) begin
            rate_q <= rate_in;
        end
    end

endmodule

// File: rtl/rsd_metric_gen.sv
module rsd_metric_gen #(
    parameter int SOFT_W = 3,
    parameter int NCH    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       honor,
    input  logic [NCH-1:0][SOFT_W-1:0] sym,
    input  logic [NCH-1:0]             erase,
    output logic [NCH-1:0][SOFT_W-1:0] bm0,
    output logic [NCH-1:0][SOFT_W-1:0] bm1
);

    localparam logic [SOFT_W-1:0] SOFT_MAX = '1;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic              kill;
        logic [SOFT_W-1:0] m0_r, m1_r;
        assign kill = honor & erase[ch];
        always_ff @(posedge clk) begin
            if (rst) begin
                m0_r <= '0;
                m1_r <= '0;
            end else if (load) begin
                m0_r <= kill ? '0 : sym[ch];
                m1_r <= kill ? '0 : SOFT_MAX - sym[ch];
            end
        end
        assign bm0[ch] = m0_r;
        assign bm1[ch] = m1_r;
    end

endmodule

// File: rtl/rsd_depunct_front.sv
module rsd_depunct_front #(
    parameter int SOFT_W = 3,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_stb,
    input  logic [SOFT_W-1:0] g1_soft,
    input  logic [SOFT_W-1:0] g2_soft,
    input  logic              g2_descr,
    input  logic              g1_erase,
    input  logic              g2_erase,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              bm_valid,
    output logic [SOFT_W-1:0] g1_bm0,
    output logic [SOFT_W-1:0] g1_bm1,
    output logic [SOFT_W-1:0] g2_bm0,
    output logic [SOFT_W-1:0] g2_bm1,
    output logic [RATE_W-1:0] bm_rate
);

    localparam int NCH = 2;

    logic                       honor_flags, sym_held;
    logic [NCH-1:0][SOFT_W-1:0] cap_sym, bm0, bm1;
    logic [NCH-1:0]             cap_erase;
    logic [RATE_W-1:0]          cap_rate;

    rsd_mode_fsm #(.RATE_W(RATE_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sym_stb     (sym_stb),
        .rate_sel    (rate_sel),
        .honor_flags (honor_flags),
        .sym_held    (sym_held)
    );

    rsd_sym_capture #(.SOFT_W(SOFT_W), .RATE_W(RATE_W), .NCH(NCH)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .sym_stb  (sym_stb),
        .sym_in   ({g2_soft, g1_soft}),
        .invert   ({g2_descr, 1'b0}),
        .erase_in ({g2_erase, g1_erase}),
        .rate_in  (rate_sel),
        .sym_q    (cap_sym),
        .erase_q  (cap_erase),
        .rate_q   (cap_rate)
    );

    rsd_metric_gen #(.SOFT_W(SOFT_W), .NCH(NCH)) u_bm (
        .clk   (clk),
        .rst   (rst),
        .load  (sym_held),
        .honor (honor_flags),
        .sym   (cap_sym),
        .erase (cap_erase),
        .bm0   (bm0),
        .bm1   (bm1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bm_valid <= 1'b0;
            bm_rate  <= '0;
        end else begin
            bm_valid <= sym_held;
            if (sym_held) begin
                bm_rate <= cap_rate;
            end
        end
    end

    assign g1_bm0 = bm0[0];
    assign g1_bm1 = bm1[0];
    assign g2_bm0 = bm0[1];
    assign g2_bm1 = bm1[1];

endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
    parameter int SOFT_W = 3,
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sym_stb,
    input logic              g1_erase,
    input logic              g2_erase,
    input logic [RATE_W-1:0] rate_sel,
    input logic              bm_valid,
    input logic [SOFT_W-1:0] g1_bm0,
    input logic [SOFT_W-1:0] g1_bm1,
    input logic [SOFT_W-1:0] g2_bm0,
    input logic [SOFT_W-1:0] g2_bm1,
    input logic [RATE_W-1:0] bm_rate
);

    localparam int SMAX = (1 << SOFT_W) - 1;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!bm_valid && g1_bm0 == '0 && g1_bm1 == '0 &&
                 g2_bm0 == '0 && g2_bm1 == '0 && bm_rate == '0));

    // R2: valid metric pairs are complementary or fully erased
    a_r2_pair_sum: assert property (@(posedge clk) disable iff (rst)
        bm_valid |->
            ((int'(g1_bm0) + int'(g1_bm1) == SMAX) || (g1_bm0 == '0 && g1_bm1 == '0)) &&
            ((int'(g2_bm0) + int'(g2_bm1) == SMAX) || (g2_bm0 == '0 && g2_bm1 == '0)));

    a_r4_g1_erased: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && rate_sel == '0 && g1_erase) |-> ##2 (g1_bm0 == '0 && g1_bm1 == '0));

    a_r5_g2_erased: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && rate_sel == '0 && g2_erase) |-> ##2 (g2_bm0 == '0 && g2_bm1 == '0));

    a_r6_flags_ignored: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && rate_sel != '0) |-> ##2
            (int'(g1_bm0) + int'(g1_bm1) == SMAX && int'(g2_bm0) + int'(g2_bm1) == SMAX));

    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        sym_stb |-> ##2 bm_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |-> ##2 !bm_valid);

    a_r8_rate_follows: assert property (@(posedge clk) disable iff (rst)
        sym_stb |-> ##2 (bm_rate == $past(rate_sel, 2)));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |-> ##2 ($stable(g1_bm0) && $stable(g1_bm1) && $stable(g2_bm0) &&
                          $stable(g2_bm1) && $stable(bm_rate)));

endmodule

bind rsd_depunct_front rsd_checker #(.SOFT_W(SOFT_W), .RATE_W(RATE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sym_stb  (sym_stb),
    .g1_erase (g1_erase),
    .g2_erase (g2_erase),
    .rate_sel (rate_sel),
    .bm_valid (bm_valid),
    .g1_bm0   (g1_bm0),
    .g1_bm1   (g1_bm1),
    .g2_bm0   (g2_bm0),
    .g2_bm1   (g2_bm1),
    .bm_rate  (bm_rate)
);

// File: tb/rsd_depunct_front_tb.sv
module rsd_depunct_front_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_stb = 1'b0;
    logic [2:0] g1_soft = '0, g2_soft = '0, rate_sel = '0;
    logic       g2_descr = 1'b0, g1_erase = 1'b0, g2_erase = 1'b0;
    logic       bm_valid;
    logic [2:0] g1_bm0, g1_bm1, g2_bm0, g2_bm1, bm_rate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    v;
        int    a0, a1, b0, b1;
        int    rate;
        string req;
    } exp_t;

    exp_t q[$];
    exp_t last;

    always #4 clk = ~clk;

    rsd_depunct_front u_dut (
        .clk(clk), .rst(rst), .sym_stb(sym_stb),
        .g1_soft(g1_soft), .g2_soft(g2_soft), .g2_descr(g2_descr),
        .g1_erase(g1_erase), .g2_erase(g2_erase), .rate_sel(rate_sel),
        .bm_valid(bm_valid), .g1_bm0(g1_bm0), .g1_bm1(g1_bm1),
        .g2_bm0(g2_bm0), .g2_bm1(g2_bm1), .bm_rate(bm_rate)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (bm_valid !== e.v || int'(g1_bm0) != e.a0 || int'(g1_bm1) != e.a1 ||
            int'(g2_bm0) != e.b0 || int'(g2_bm1) != e.b1 || int'(bm_rate) != e.rate) begin
            errors++;
            $display("FAIL %s: got v=%0d g1=(%0d,%0d) g2=(%0d,%0d) rate=%0d, expected v=%0d g1=(%0d,%0d) g2=(%0d,%0d) rate=%0d",
                     e.req, bm_valid, g1_bm0, g1_bm1, g2_bm0, g2_bm1, bm_rate,
                     e.v, e.a0, e.a1, e.b0, e.b1, e.rate);
        end
    endtask

    function automatic exp_t zero_entry();
        exp_t z;
        z.v = 0; z.a0 = 0; z.a1 = 0; z.b0 = 0; z.b1 = 0; z.rate = 0; z.req = "R1";
        return z;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        if (q.size() == 2) compare(q.pop_front());
        rst = 1'b1; sym_stb = 1'b0;
        q.delete();
        q.push_back(zero_entry());
        q.push_back(zero_entry());
        last = zero_entry();
        @(negedge clk);
        compare(q.pop_front());
        q.push_back(zero_entry());
        @(negedge clk);
        compare(q.pop_front());
        rst = 1'b0;
        q.push_back(zero_entry());
    endtask

    task automatic step(input bit stb, input int g1, input int g2, input bit d,
                        input bit e1, input bit e2, input int rate, input string req);
        exp_t e;
        int v2;
        bit honour;
        @(negedge clk);
        if (q.size() == 2) compare(q.pop_front());
        sym_stb = stb; g1_soft = 3'(g1); g2_soft = 3'(g2); g2_descr = d;
        g1_erase = e1; g2_erase = e2; rate_sel = 3'(rate);
        e = last;
        e.req = req;
        e.v = stb;
        if (stb) begin
            v2 = d ? 7 - g2 : g2;
            honour = (rate == 0);
            e.a0 = (honour && e1) ? 0 : g1;
            e.a1 = (honour && e1) ? 0 : 7 - g1;
            e.b0 = (honour && e2) ? 0 : v2;
            e.b1 = (honour && e2) ? 0 : 7 - v2;
            e.rate = rate;
        end
        last = e;
        q.push_back(e);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        do_reset();                                            // R1
        for (int a = 0; a < 8; a++)                            // R2 sweep, back-to-back
            for (int b = 0; b < 8; b++)
                step(1, a, b, 0, 0, 0, 0, "R2");
        for (int a = 0; a < 8; a++)                            // R3 inversion on G2 only
            step(1, a, 7 - a, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 40; i++)                           // R4 G1 erased, any pins
            step(1, $urandom_range(7), $urandom_range(7), i[0], 1, 0, 0, "R4");
        for (int i = 0; i < 40; i++)                           // R5 G2 erased, any pins
            step(1, $urandom_range(7), $urandom_range(7), i[1], 0, 1, 0, "R5");
        for (int i = 0; i < 30; i++)                           // R4/R5 both erased
            step(1, $urandom_range(7), $urandom_range(7), 1, 1, 1, 0, "R4_R5");
        for (int i = 0; i < 40; i++)                           // R6 flags ignored
            step(1, $urandom_range(7), $urandom_range(7), i[0], 1, 1,
                 1 + $urandom_range(6), "R6");
        for (int i = 0; i < 60; i++)                           // R7 strobe gaps
            step(i % 3 != 1, $urandom_range(7), $urandom_range(7), i[2],
                 i[0], i[1], i % 2 ? 0 : 5, "R7");
        for (int r = 0; r < 8; r++) begin                      // R8 rate tag
            step(1, r, 7 - r, 0, 1, 0, r, "R8");
            step(0, 0, 0, 0, 0, 0, 0, "R8");
        end
        step(1, 3, 6, 0, 0, 0, 4, "R9");                       // R9 hold
        for (int i = 0; i < 10; i++)
            step(0, $urandom_range(7), $urandom_range(7), 1, 1, 1, 0, "R9");
        do_reset();                                            // R1 mid-run
        for (int i = 0; i < 200; i++)                          // mixed
            step($urandom_range(3) != 0, $urandom_range(7), $urandom_range(7),
                 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                 $urandom_range(1) ? 0 : $urandom_range(7), "R2_R7");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule